// File: doc/BRIEF.md
# Run-Time Selectable Memory Width Bridge

This block joins a fixed 32-bit application port to a memory data path whose width is picked while the chip runs: 32, 16 or 8 bits. A 2-bit width select input chooses the mode. Requests pass through the bridge on their way downstream. The bridge rescales the word address and the word count into memory-width units. The request and acknowledge signals themselves go straight through.

On the write side, a four-state splitter (SPL_LANE0 to SPL_LANE3) walks through the slices of the current application word. It advances one state each time the transfer engine strobes that a beat has been consumed. After the final slice of the word it wraps back to SPL_LANE0, and in that same cycle it asks the application for the next word. In 32-bit mode the final slice is the one in SPL_LANE0, in 16-bit mode the one in SPL_LANE1, and in 8-bit mode the one in SPL_LANE3.

On the read side, a four-state packer (PCK_LANE0 to PCK_LANE3) collects incoming beats into a holding word. It advances one state on each read beat. When the final slice arrives, it emits the whole word with a one-cycle valid pulse and returns to PCK_LANE0. A burst-end strobe on any beat also returns it to PCK_LANE0 and drops whatever partial word it was holding. The width select is expected to change only while the block is held in reset or between bursts.

Top module: `memwidth_bridge`

## Requirements
- R1: The width select decodes as follows: 2'b00 gives 32-bit mode with 1 beat per word, 2'b01 gives 16-bit mode with 2 beats per word, and any value with bit 1 set gives 8-bit mode with 4 beats per word.
- R2: dn_len equals app_len shifted left by 0, 1 or 2 in 32-, 16- or 8-bit mode. This is combinational, in the same cycle.
- R3: dn_addr equals app_addr shifted left by 0, 1 or 2 in 32-, 16- or 8-bit mode, so the new low bits are zero. This is combinational.
- R4: dn_req follows app_req, dn_wr_n follows app_wr_n, and app_ack follows dn_ack, all in the same cycle.
- R5: Write beat k carries the application data bits [16k+15:16k] in 16-bit mode, or bits [8k+7:8k] in 8-bit mode, on eng_wdata starting at bit 0. The unused upper bits of eng_wdata are zero. In 32-bit mode the whole word passes unchanged.
- R6: On write beat k, the low lanes of eng_wbe_n carry the active-low byte enables of that beat's slice. Unused upper enable bits are driven 1, meaning masked.
- R7: app_wnext is 1 only in a cycle where eng_wnext is 1 and the current beat is the last beat of the word. Each such strobe moves the splitter back to beat 0.
- R8: In 16-bit mode, read beat k fills word bits [16k+15:16k] from eng_rdata[15:0]. In 8-bit mode, read beat k fills word bits [8k+7:8k] from eng_rdata[7:0].
- R9: app_rvalid is high for exactly one cycle, the cycle after the beat that completes a word, with that word on app_rdata. It is 0 at all other times.
- R10: A read beat with eng_rlast set returns the packer to beat 0 and discards any partial word. No valid is raised unless that beat completed the word.
- R11: While reset is asserted and right after it, app_rvalid is 0 and both the splitter and the packer sit at beat 0.
- R12: In 32-bit mode, every read beat yields app_rvalid in the next cycle, with eng_rdata unchanged on app_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| width_sel | input | 2 | Memory width select (00 = 32, 01 = 16, 1x = 8) |
| app_req | input | 1 | Application request |
| app_wr_n | input | 1 | Request direction, 0 = write, 1 = read |
| app_addr | input | AW | Request word address |
| app_len | input | LW | Request length in 32-bit words |
| app_ack | output | 1 | Acknowledge returned to the application |
| dn_req | output | 1 | Request to the downstream engine |
| dn_wr_n | output | 1 | Direction to the downstream engine |
| dn_addr | output | AW+2 | Address in memory-width units |
| dn_len | output | LW+2 | Length in memory-width beats |
| dn_ack | input | 1 | Acknowledge from the downstream engine |
| app_wdata | input | 32 | Application write word |
| app_wbe_n | input | 4 | Active-low byte write enables |
| app_wnext | output | 1 | Request for the next write word |
| eng_wnext | input | 1 | Engine has consumed the current write beat |
| eng_wdata | output | 32 | Write beat, right aligned |
| eng_wbe_n | output | 4 | Beat byte enables, right aligned, unused bits 1 |
| eng_rdata | input | 32 | Read beat, right aligned |
| eng_rvalid | input | 1 | Read beat strobe |
| eng_rlast | input | 1 | Last read beat of the burst |
| app_rdata | output | 32 | Packed read word |
| app_rvalid | output | 1 | One-cycle valid pulse for app_rdata |

## Verification
The bench goes after the wrap points of both state machines in every mode.

A splitter that wraps one slice early or late would raise app_wnext on the wrong beat, and every later slice would come out of the wrong byte lanes. A packer that wraps wrongly would pulse valid too often or too rarely, with words assembled from mixed beats.

Burst ends on a partial word are driven on purpose. A design that kept the stale lanes, or did not return to beat 0, would emit a corrupted or early word on the next burst.

Enable masking of the unused upper lanes is checked in every mode, and so are the low zero bits of the rescaled address and length, since an off-by-one shift would show up in exactly those bits.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    localparam int APP_DW     = 32;
    localparam int APP_BYTES  = APP_DW / 8;
    localparam int SCALE_BITS = 2;

    typedef enum logic [1:0] {
        MW_32 = 2'd0,
        MW_16 = 2'd1,
        MW_8  = 2'd2
    } mw_mode_e;

    typedef enum logic [1:0] {
        SPL_LANE0 = 2'd0,
        SPL_LANE1 = 2'd1,
        SPL_LANE2 = 2'd2,
        SPL_LANE3 = 2'd3
    } split_st_e;

    typedef enum logic [1:0] {
        PCK_LANE0 = 2'd0,
        PCK_LANE1 = 2'd1,
        PCK_LANE2 = 2'd2,
        PCK_LANE3 = 2'd3
    } pack_st_e;

endpackage

// File: rtl/mwb_mode_dec.sv
module mwb_mode_dec
    import mwb_pkg::*;
(
    input  logic [1:0] width_sel,
    output mw_mode_e   mode,
    output logic [1:0] shift,
    output logic [1:0] last_idx
);

    // R1: width decode
    always_comb begin
        unique casez (width_sel)
            2'b00:   mode = MW_32;
            2'b01:   mode = MW_16;
            2'b1?:   mode = MW_8;
            default: mode = MW_8;
        endcase
    end

    always_comb begin
        unique case (mode)
            MW_32: begin shift = 2'd0; last_idx = 2'd0; end
            MW_16: begin shift = 2'd1; last_idx = 2'd1; end
            MW_8:  begin shift = 2'd2; last_idx = 2'd3; end
            default: begin shift = 2'd2; last_idx = 2'd3; end
        endcase
    end

endmodule

// File: rtl/mwb_req_scale.sv
module mwb_req_scale
    import mwb_pkg::*;
#(
    parameter int AW = 24,
    parameter int LW = 9
) (
    input  logic [1:0]               shift,
    input  logic                     app_req,
    input  logic                     app_wr_n,
    input  logic [AW-1:0]            app_addr,
    input  logic [LW-1:0]            app_len,
    output logic                     app_ack,
    output logic                     dn_req,
    output logic                     dn_wr_n,
    output logic [AW+SCALE_BITS-1:0] dn_addr,
    output logic [LW+SCALE_BITS-1:0] dn_len,
    input  logic                     dn_ack
);

    localparam int DAW = AW + SCALE_BITS;
    localparam int DLW = LW + SCALE_BITS;

    logic [DAW-1:0] addr_ext;
    logic [DLW-1:0] len_ext;

    assign addr_ext = {{SCALE_BITS{1'b0}}, app_addr};
    assign len_ext  = {{SCALE_BITS{1'b0}}, app_len};

    // R2, R3: rescale to device-width units
    always_comb begin
        dn_addr = addr_ext << shift;
        dn_len  = len_ext << shift;
    end

    // R4: handshakes pass through
    assign dn_req  = app_req;
    assign dn_wr_n = app_wr_n;
    assign app_ack = dn_ack;

endmodule

// File: rtl/mwb_wr_split.sv
module mwb_wr_split
    import mwb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  mw_mode_e             mode,
    input  logic [1:0]           shift,
    input  logic [1:0]           last_idx,
    input  logic [APP_DW-1:0]    app_wdata,
    input  logic [APP_BYTES-1:0] app_wbe_n,
    output logic                 app_wnext,
    input  logic                 eng_wnext,
    output logic [APP_DW-1:0]    eng_wdata,
    output logic [APP_BYTES-1:0] eng_wbe_n
);

    split_st_e state, state_nx;
    logic [1:0] idx;
    logic       at_last;

    assign idx     = state;
    assign at_last = (idx == last_idx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SPL_LANE0;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (eng_wnext) begin
            if (at_last) begin
                state_nx = SPL_LANE0;
            end else begin
                unique case (state)
                    SPL_LANE0: state_nx = SPL_LANE1;
                    SPL_LANE1: state_nx = SPL_LANE2;
                    SPL_LANE2: state_nx = SPL_LANE3;
                    SPL_LANE3: state_nx = SPL_LANE0;
                    default:   state_nx = SPL_LANE0;
                endcase
            end
        end
    end

    // R7: next word request
    assign app_wnext = eng_wnext && at_last;

    // R5, R6: per byte lane selection
    for (genvar g = 0; g < APP_BYTES; g++) begin : g_lane
        logic [1:0] src;
        logic       used;
        always_comb begin
            src  = 2'((int'(idx) << (2 - int'(shift))) + g);
            used = (g < (APP_BYTES >> shift));
            if (used) begin
                eng_wdata[g*8 +: 8] = app_wdata[int'(src)*8 +: 8];
                eng_wbe_n[g]        = app_wbe_n[src];
            end else begin
                eng_wdata[g*8 +: 8] = 8'h00;
                eng_wbe_n[g]        = 1'b1;
            end
        end
    end

    p_wnext_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        app_wnext |-> eng_wnext);

    p_wbe_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MW_8) |-> (eng_wbe_n[3:1] == 3'b111));

    p_wdata_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MW_16) |-> (eng_wdata[31:16] == 16'h0000));

endmodule

// File: rtl/mwb_rd_pack.sv
module mwb_rd_pack
    import mwb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mw_mode_e          mode,
    input  logic [1:0]        shift,
    input  logic [1:0]        last_idx,
    input  logic [APP_DW-1:0] eng_rdata,
    input  logic              eng_rvalid,
    input  logic              eng_rlast,
    output logic [APP_DW-1:0] app_rdata,
    output logic              app_rvalid
);

    pack_st_e state, state_nx;
    logic [1:0]        idx;
    logic              complete;
    logic              restart;
    logic [APP_DW-1:0] hold;
    logic [APP_DW-1:0] merged;

    assign idx      = state;
    assign complete = eng_rvalid && (idx == last_idx);
    assign restart  = complete || (eng_rvalid && eng_rlast);

    // R8: lane insertion
    for (genvar g = 0; g < APP_BYTES; g++) begin : g_lane
        logic [1:0] owner;
        logic [1:0] srcb;
        always_comb begin
            owner = 2'(g >> (2 - int'(shift)));
            srcb  = 2'(g & ((APP_BYTES >> shift) - 1));
            if (owner == idx) merged[g*8 +: 8] = eng_rdata[int'(srcb)*8 +: 8];
            else              merged[g*8 +: 8] = hold[g*8 +: 8];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PCK_LANE0;
        else        state <= state_nx;
    end

    // transitions (R10)
    always_comb begin
        state_nx = state;
        if (eng_rvalid) begin
            if (restart) begin
                state_nx = PCK_LANE0;
            end else begin
                unique case (state)
                    PCK_LANE0: state_nx = PCK_LANE1;
                    PCK_LANE1: state_nx = PCK_LANE2;
                    PCK_LANE2: state_nx = PCK_LANE3;
                    PCK_LANE3: state_nx = PCK_LANE0;
                    default:   state_nx = PCK_LANE0;
                endcase
            end
        end
    end

    // outputs (R9, R11)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold       <= '0;
            app_rdata  <= '0;
            app_rvalid <= 1'b0;
        end else begin
            app_rvalid <= complete;
            if (complete) app_rdata <= merged;
            if (eng_rvalid) hold <= restart ? '0 : merged;
        end
    end

    p_rvalid_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        app_rvalid |-> $past(eng_rvalid));

    p_rlast_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rvalid && eng_rlast) |=> (state == PCK_LANE0));

    p_word_each_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MW_32 && eng_rvalid) |=> app_rvalid);

endmodule

// File: rtl/memwidth_bridge.sv
module memwidth_bridge
    import mwb_pkg::*;
#(
    parameter int AW = 24,
    parameter int LW = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         width_sel,
    input  logic               app_req,
    input  logic               app_wr_n,
    input  logic [AW-1:0]      app_addr,
    input  logic [LW-1:0]      app_len,
    output logic               app_ack,
    output logic               dn_req,
    output logic               dn_wr_n,
    output logic [AW+1:0]      dn_addr,
    output logic [LW+1:0]      dn_len,
    input  logic               dn_ack,
    input  logic [31:0]        app_wdata,
    input  logic [3:0]         app_wbe_n,
    output logic               app_wnext,
    input  logic               eng_wnext,
    output logic [31:0]        eng_wdata,
    output logic [3:0]         eng_wbe_n,
    input  logic [31:0]        eng_rdata,
    input  logic               eng_rvalid,
    input  logic               eng_rlast,
    output logic [31:0]        app_rdata,
    output logic               app_rvalid
);

    mw_mode_e   mode;
    logic [1:0] shift;
    logic [1:0] last_idx;

    mwb_mode_dec u_dec (
        .width_sel (width_sel),
        .mode      (mode),
        .shift     (shift),
        .last_idx  (last_idx)
    );

    mwb_req_scale #(.AW(AW), .LW(LW)) u_req (
        .shift     (shift),
        .app_req   (app_req),
        .app_wr_n  (app_wr_n),
        .app_addr  (app_addr),
        .app_len   (app_len),
        .app_ack   (app_ack),
        .dn_req    (dn_req),
        .dn_wr_n   (dn_wr_n),
        .dn_addr   (dn_addr),
        .dn_len    (dn_len),
        .dn_ack    (dn_ack)
    );

    mwb_wr_split u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .shift     (shift),
        .last_idx  (last_idx),
        .app_wdata (app_wdata),
        .app_wbe_n (app_wbe_n),
        .app_wnext (app_wnext),
        .eng_wnext (eng_wnext),
        .eng_wdata (eng_wdata),
        .eng_wbe_n (eng_wbe_n)
    );

    mwb_rd_pack u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .shift      (shift),
        .last_idx   (last_idx),
        .eng_rdata  (eng_rdata),
        .eng_rvalid (eng_rvalid),
        .eng_rlast  (eng_rlast),
        .app_rdata  (app_rdata),
        .app_rvalid (app_rvalid)
    );

    p_addr_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MW_8) |-> (dn_addr[1:0] == 2'b00 && dn_len[1:0] == 2'b00));

    p_len_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MW_16) |-> (dn_len[0] == 1'b0 && dn_addr[0] == 1'b0));

endmodule

// File: tb/tb_memwidth_bridge.sv
module tb_memwidth_bridge;

    localparam int AW = 24;
    localparam int LW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    width_sel = 2'b00;
    logic          app_req = 1'b0, app_wr_n = 1'b1, dn_ack = 1'b0;
    logic [AW-1:0] app_addr = '0;
    logic [LW-1:0] app_len = '0;
    logic          app_ack, dn_req, dn_wr_n;
    logic [AW+1:0] dn_addr;
    logic [LW+1:0] dn_len;
    logic [31:0]   app_wdata = '0, eng_wdata, eng_rdata = '0, app_rdata;
    logic [3:0]    app_wbe_n = 4'hF, eng_wbe_n;
    logic          app_wnext, eng_wnext = 1'b0;
    logic          eng_rvalid = 1'b0, eng_rlast = 1'b0, app_rvalid;

    int tests = 0;
    int fails = 0;

    // reference model state
    int      m_widx = 0;
    int      m_rpos = 0;
    logic [7:0] m_bytes [4];
    logic    m_rv = 1'b0;
    logic [31:0] m_rd = '0;

    always #4 clk = ~clk;

    memwidth_bridge #(.AW(AW), .LW(LW)) dut (.*);

    function automatic int beats_of(input logic [1:0] s);
        if (s == 2'b00) return 1;
        if (s == 2'b01) return 2;
        return 4;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare at the current negedge, then advance model over the next posedge
    task automatic tick();
        int nb, w, sh;
        logic [31:0] exp_d;
        logic [3:0]  exp_be;
        #1;
        nb = beats_of(width_sel);
        sh = (nb == 1) ? 0 : (nb == 2) ? 1 : 2;
        w  = 32 / nb;
        exp_d  = (app_wdata >> (w * m_widx)) & ((nb == 1) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1));
        exp_be = ((app_wbe_n >> ((4 / nb) * m_widx)) & 4'((1 << (4 / nb)) - 1))
               | ~4'((1 << (4 / nb)) - 1);
        chk("R5 wdata", 64'(eng_wdata), 64'(exp_d));
        chk("R6 wbe_n", 64'(eng_wbe_n), 64'(exp_be));
        chk("R7 wnext", 64'(app_wnext), 64'(eng_wnext && (m_widx == nb - 1)));
        chk("R3 addr", 64'(dn_addr), 64'(AW'(app_addr)) * (64'd1 << sh));
        chk("R2 len", 64'(dn_len), 64'(app_len) * (64'd1 << sh));
        chk("R4 handshake", 64'({dn_req, dn_wr_n, app_ack}), 64'({app_req, app_wr_n, dn_ack}));
        chk("R9 rvalid", 64'(app_rvalid), 64'(m_rv));
        if (m_rv) chk(nb == 1 ? "R12 rdata" : "R8 rdata", 64'(app_rdata), 64'(m_rd));
        // advance model
        if (eng_wnext) m_widx = (m_widx + 1 == nb) ? 0 : m_widx + 1;
        m_rv = 1'b0;
        if (eng_rvalid) begin
            for (int j = 0; j < 4 / nb; j++) begin
                m_bytes[m_rpos] = eng_rdata[j*8 +: 8];
                m_rpos++;
            end
            if (m_rpos == 4) begin
                m_rv = 1'b1;
                m_rd = {m_bytes[3], m_bytes[2], m_bytes[1], m_bytes[0]};
                m_rpos = 0;
            end
            if (eng_rlast) m_rpos = 0; // R10
        end
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk);
        rst_n = 1'b0;
        width_sel = sel;
        eng_wnext = 1'b0; eng_rvalid = 1'b0; eng_rlast = 1'b0;
        m_widx = 0; m_rpos = 0; m_rv = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 rvalid in reset", 64'(app_rvalid), 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic rbeat(input logic [31:0] d, input logic last);
        eng_rvalid = 1'b1; eng_rlast = last; eng_rdata = d;
        tick();
        eng_rvalid = 1'b0; eng_rlast = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            // R11: first write beat presents slice 0 after reset
            app_wdata = 32'hA1B2_C3D4; app_wbe_n = 4'b0110;
            tick();
            // R10: partial word closed by burst end, then a clean word (R1, R8)
            rbeat(32'h0000_00EE, 1'b1);
            tick();
            for (int k = 0; k < beats_of(2'(s)); k++)
                rbeat(32'h1111_1111 * (k + 3), 1'b0);
            tick();
            tick();
            // randomised traffic
            for (int c = 0; c < 400; c++) begin
                app_req   = 1'($urandom);
                app_wr_n  = 1'($urandom);
                dn_ack    = 1'($urandom);
                app_addr  = AW'($urandom);
                app_len   = LW'($urandom);
                if (app_wnext || c % 7 == 0) begin
                    app_wdata = $urandom;
                    app_wbe_n = 4'($urandom);
                end
                eng_wnext  = 1'($urandom);
                eng_rvalid = 1'($urandom);
                eng_rlast  = ($urandom % 9) == 0;
                eng_rdata  = $urandom;
                tick();
            end
            eng_wnext = 1'b0; eng_rvalid = 1'b0; eng_rlast = 1'b0;
            tick();
            tick();
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule